// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers eight interrupt request lines from peripherals and presents one interrupt line to a processor. A rising transition on a request line is latched as pending. The lowest-numbered pending source wins, so line 0 has the highest priority. The winner is offered to the processor only when no source of equal or higher priority is already being serviced.

The processor answers with two acknowledge pulses. The first pulse moves the winning source from the pending set into the in-service set and withdraws the interrupt line. The second pulse makes the controller present an 8-bit vector. The upper bits of the vector are a programmable base and the lower bits are the source number. The vector stays on the bus until the second pulse ends. When the handler finishes, the processor pulses end-of-service, which retires the highest-priority in-service source. That unmasks lower-priority work.

Top module: `prio_vec_irq`

## Requirements
- R1: A 0-to-1 transition on `req_i[k]` (sampled on the clock) marks source k pending. A line held high after its bit has been taken does not mark it pending again.
- R2: In the idle phase, `irq_o` is high exactly when some source is pending and nothing in service has equal or higher priority. With nothing in service, any pending source raises it.
- R3: Priority is fixed: the lowest source index among pending sources is the one the first acknowledge takes.
- R4: On the clock where `ack_i` is first seen high in the idle phase with an eligible source, that source leaves the pending set and enters the in-service set. `irq_o` is low from the next cycle until the handshake ends.
- R5: On the clock where `ack_i` is first seen high for the second pulse, `vec_valid_o` rises and `vec_o` = {`base_i`, 3-bit source index}. Both hold until the clock where `ack_i` is first seen low again, after which `vec_valid_o` is low.
- R6: `vec_o` is all zeros whenever `vec_valid_o` is low.
- R7: While a source is in service, pending sources of equal or lower priority keep `irq_o` low. A pending source of strictly higher priority raises it, and can be taken as a nested interrupt.
- R8: A one-cycle `eos_i` pulse clears only the highest-priority (lowest index) in-service bit.
- R9: If `req_i[k]` rises on the same clock that the first acknowledge takes source k, source k stays pending afterwards.
- R10: A first acknowledge with no eligible source changes neither set, and the handshake completes with vector {`base_i`, 3'd7}.
- R11: After reset nothing is pending or in service, and `irq_o`, `vec_valid_o` and `vec_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 8 | Request lines, index 0 highest priority |
| ack_i | input | 1 | Acknowledge pulse from the processor, active high |
| eos_i | input | 1 | End-of-service pulse, one cycle |
| base_i | input | 5 | Upper bits of every vector |
| irq_o | output | 1 | Interrupt toward the processor |
| vec_valid_o | output | 1 | Vector on `vec_o` is valid |
| vec_o | output | 8 | Interrupt vector |

## Verification
The assertions assume well-formed acknowledge pulses: each pulse is high for at least one clock and separated from the next by at least one low clock. They also assume `eos_i` lasts one cycle. The vector-hold check also relies on `base_i` not mattering once the vector is loaded, because the vector is captured only at the second rise. The stimulus always issues complete pairs of two-cycle pulses with one low cycle between them, and changes `base_i` only between handshakes. It also pulses `eos_i` only for a single cycle, sometimes with nothing in service, which is legal and must be a no-op.

// File: rtl/prio_vec_irq.sv
module prio_vec_irq #(
  parameter  int N     = 8,
  parameter  int VW    = 8,
  localparam int IDXW  = $clog2(N),
  localparam int BASEW = VW - IDXW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req_i,
  input  logic             ack_i,
  input  logic             eos_i,
  input  logic [BASEW-1:0] base_i,
  output logic             irq_o,
  output logic             vec_valid_o,
  output logic [VW-1:0]    vec_o
);

  typedef enum logic [1:0] {ST_IDLE, ST_HELD, ST_VEC} phase_t;

  phase_t          state;
  logic [N-1:0]    req_q, pend, insvc, take_m, done_m;
  logic            ack_q;
  logic [IDXW-1:0] top_p, top_s, sel_idx;
  logic            pend_any, svc_any, elig, ack_rise, ack_fall, commit;

  always_comb begin
    top_p = '0;
    top_s = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i])  top_p = IDXW'(i);
      if (insvc[i]) top_s = IDXW'(i);
    end
  end

  assign pend_any = |pend;
  assign svc_any  = |insvc;
  assign elig     = pend_any && (!svc_any || top_p < top_s);
  assign ack_rise = ack_i & ~ack_q;
  assign ack_fall = ~ack_i & ack_q;
  assign commit   = (state == ST_IDLE) && ack_rise && elig;
  assign take_m   = commit ? (N'(1) << top_p) : '0;
  assign done_m   = (eos_i && svc_any) ? (N'(1) << top_s) : '0;
  assign irq_o    = (state == ST_IDLE) && elig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      ack_q <= 1'b0;
      pend  <= '0;
      insvc <= '0;
    end else begin
      req_q <= req_i;
      ack_q <= ack_i;
      pend  <= (pend & ~take_m) | (req_i & ~req_q);
      insvc <= (insvc & ~done_m) | take_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      sel_idx     <= '0;
      vec_valid_o <= 1'b0;
      vec_o       <= '0;
    end else begin
      case (state)
        ST_IDLE: if (ack_rise) begin
          state   <= ST_HELD;
          sel_idx <= elig ? top_p : IDXW'(N - 1);
        end
        ST_HELD: if (ack_rise) begin
          state       <= ST_VEC;
          vec_valid_o <= 1'b1;
          vec_o       <= {base_i, sel_idx};
        end
        ST_VEC: if (ack_fall) begin
          state       <= ST_IDLE;
          vec_valid_o <= 1'b0;
          vec_o       <= '0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_irq_has_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> pend_any);

  assert_irq_drops_on_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !irq_o);

  assert_commit_records_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> insvc[$past(top_p)]);

  assert_eos_clears_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eos_i && svc_any && !commit) |=> $countones(insvc) == $countones($past(insvc)) - 1);

  assert_vec_zero_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid_o |-> vec_o == '0);

  assert_vec_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(vec_valid_o) && vec_valid_o) |-> $stable(vec_o));

  assert_req_edge_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && req_i[top_p] && !req_q[top_p]) |=> pend[$past(top_p)]);

endmodule

// File: tb/prio_vec_irq_test.sv
module prio_vec_irq_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_i = '0;
  logic       ack_i = 1'b0;
  logic       eos_i = 1'b0;
  logic [4:0] base_i = 5'h0A;
  logic       irq_o, vec_valid_o;
  logic [7:0] vec_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural model state
  bit m_pend[8], m_isr[8];
  bit [7:0] m_reqq;
  bit m_ackq, m_valid;
  int m_phase, m_idx, m_vec;

  prio_vec_irq uut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .ack_i(ack_i), .eos_i(eos_i),
    .base_i(base_i), .irq_o(irq_o), .vec_valid_o(vec_valid_o), .vec_o(vec_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int lowest(input bit v[8]);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic bit exp_irq();
    int tp = lowest(m_pend);
    int ts = lowest(m_isr);
    return (m_phase == 0) && tp >= 0 && (ts < 0 || tp < ts);
  endfunction

  task automatic model_step(input bit [7:0] r, input bit a, input bit e, input int base);
    int  tp = lowest(m_pend);
    int  ts = lowest(m_isr);
    bit  el = tp >= 0 && (ts < 0 || tp < ts);
    bit  arise = a && !m_ackq;
    bit  afall = !a && m_ackq;
    if (e && ts >= 0) m_isr[ts] = 0;
    case (m_phase)
      0: if (arise) begin
        m_phase = 1;
        if (el) begin m_idx = tp; m_pend[tp] = 0; m_isr[tp] = 1; end
        else m_idx = 7;
      end
      1: if (arise) begin m_phase = 2; m_valid = 1; m_vec = base * 8 + m_idx; end
      default: if (afall) begin m_phase = 0; m_valid = 0; m_vec = 0; end
    endcase
    for (int i = 0; i < 8; i++) if (r[i] && !m_reqq[i]) m_pend[i] = 1;
    m_reqq = r;
    m_ackq = a;
  endtask

  task automatic compare(input string tag);
    bit ei = exp_irq();
    checks++;
    if (irq_o !== ei || vec_valid_o !== m_valid || vec_o !== 8'(m_vec)) begin
      fails++;
      $display("FAIL %s: irq/valid/vec actual=%0b/%0b/%02h expected=%0b/%0b/%02h",
               tag, irq_o, vec_valid_o, vec_o, ei, m_valid, 8'(m_vec));
    end
  endtask

  task automatic cyc(input bit a, input bit e, input string tag);
    ack_i = a;
    eos_i = e;
    @(posedge clk);
    @(negedge clk);
    model_step(req_i, a, e, int'(base_i));
    compare(tag);
  endtask

  task automatic handshake(input string tag);
    cyc(1, 0, tag); cyc(1, 0, tag); cyc(0, 0, tag);
    cyc(1, 0, tag); cyc(1, 0, tag); cyc(0, 0, tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, tag);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin m_pend[i] = 0; m_isr[i] = 0; end
    m_reqq = '0; m_ackq = 0; m_valid = 0; m_phase = 0; m_idx = 0; m_vec = 0;
    repeat (3) @(negedge clk);
    compare("R11 reset");
    rst_n = 1'b1;
    idle(2, "R11 after reset");

    // single source through a full handshake
    req_i[5] = 1; idle(2, "R1 R2 source 5 pending");
    req_i[5] = 0; handshake("R4 R5 R6 vector for source 5");
    idle(2, "R7 in service, nothing else");
    cyc(0, 1, "R8 eos source 5");
    idle(1, "R11 quiet");

    // simultaneous requests, nesting
    req_i[6] = 1; req_i[2] = 1; idle(2, "R3 two sources");
    req_i = '0; handshake("R3 source 2 wins");
    idle(2, "R7 source 6 blocked");
    req_i[0] = 1; idle(2, "R7 higher source 0 raises irq");
    req_i[0] = 0; base_i = 5'h13; handshake("R7 nested source 0");
    cyc(0, 1, "R8 eos clears source 0 only");
    idle(2, "R7 source 6 still blocked by 2");
    cyc(0, 1, "R8 eos clears source 2");
    idle(1, "R2 source 6 offered");
    handshake("R3 source 6 served");
    cyc(0, 1, "R8 eos source 6");

    // request edge coinciding with the take
    req_i[3] = 1; idle(1, "R1 source 3 edge");
    req_i[3] = 0; idle(1, "R1 source 3 line drop");
    req_i[3] = 1; cyc(1, 0, "R9 re-request on take");
    cyc(1, 0, "R9"); cyc(0, 0, "R9"); cyc(1, 0, "R9"); cyc(1, 0, "R9"); cyc(0, 0, "R9");
    cyc(0, 1, "R9 eos then source 3 again");
    idle(2, "R9 source 3 kept");
    handshake("R9 second service of 3");
    cyc(0, 1, "R8 eos source 3");
    idle(3, "R1 held line does not retrigger");
    req_i[3] = 0;

    // level held through service
    req_i[4] = 1; idle(1, "R1 source 4");
    handshake("R1 source 4 with line held");
    cyc(0, 1, "R8 eos source 4");
    idle(3, "R1 no retrigger for source 4");
    req_i[4] = 0;

    // spurious handshake and eos with nothing in service
    base_i = 5'h1F;
    handshake("R10 spurious vector");
    cyc(0, 1, "R8 eos with empty set");
    req_i[1] = 1; idle(1, "R10 sets untouched after spurious");
    req_i[1] = 0; handshake("R10 normal after spurious");
    cyc(0, 1, "R8 eos source 1");
    idle(2, "R11 end idle");

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule